// File: doc/BRIEF.md
# Posted-Write Pending Tracker

This block sits between a register bus running on a bus clock and a timer core that runs on its own, slower functional clock. It carries writes for five timer registers into the functional domain.

In posted mode the bus write finishes in the cycle it is presented. The block keeps the data and sets a pending flag for that register. The flag stays set until a toggle handshake has carried the write across and the acknowledge has come back. Software reads a status word that holds all the pending flags, and it waits for the relevant flag to clear before it touches that register again. While a flag is set:

- a second write to the same register is dropped;
- a read of that register gets an error response.

In non-posted mode the bus is stalled instead, and the write completes only once the acknowledge has returned. Posted mode is chosen at run time and is on after reset.

The block also handles a few things locally:

- Registers that have no pending flag are passed straight to the core with an immediate strobe.
- A soft-reset request crosses the same kind of handshake.
- A reset-done bit reports when the soft reset has finished.

The bus controller is a three-state machine:

- `S_IDLE` accepts transfers.
- `S_HOLD` stalls a non-posted write until an older pending write to the same register clears.
- `S_WAIT` stalls a non-posted write until its own acknowledge returns.

Its transitions are:

- IDLE→WAIT: a non-posted tracked write arrives while the target flag is clear. The write is launched.
- IDLE→HOLD: a non-posted tracked write arrives while the target flag is still set.
- HOLD→WAIT: the old flag clears. The write is launched.
- WAIT→IDLE: the flag clears. Ready is given.

Every other case stays in its state.

Top module: `pwt_tracker`

## Requirements
- R1: After reset the pending word (offset 0x34) reads 0, the interface control word (offset 0x40) reads 4 (bit 2 = posted mode on, bit 1 = soft reset in progress), the system status word (offset 0x14) bit 0 reads 1, and the bus is ready.
- R2: In posted mode a write to a tracked register (control 0x24, counter 0x28, load 0x2C, trigger 0x30, match 0x38) is accepted in its first cycle with ready high. The next read of offset 0x34 shows that register's flag set. The flag positions are: bit 0 control, bit 1 counter, bit 2 load, bit 3 trigger, bit 4 match.
- R3: Each accepted tracked write produces exactly one functional-domain strobe for that register, carrying the written data. The register's flag then clears without further bus action.
- R4: In posted mode a write to a tracked register whose flag is still set is dropped. The core receives only the earlier data.
- R5: A read of a tracked register while its flag is set returns an error response. Once the flag is clear, the read returns the last accepted data without error.
- R6: A write to any address that is neither tracked nor local (for example 0x1C) completes at once, with the immediate-write strobe high in the accepting cycle, and sets no pending flag.
- R7: When bit 2 of 0x40 is written 0, a tracked write holds ready low until its acknowledge returns. After the write completes, the pending word reads 0 and the core has the data.
- R8: Writing 1 to bit 1 of 0x40 starts a soft reset. The system status bit 0 then reads 0, the core sees one soft-reset strobe, and the bit returns to 1. On completion, posted mode is restored to on.
- R9: Writes to offsets 0x34 and 0x14 have no effect, and reads of the local words never return an error.
- R10: A pending write to one register does not block a posted write to another. Both flags can be set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Bus-domain reset, active low |
| bus_sel | input | 1 | Transfer request, held until ready |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset |
| bus_wdata | input | DW | Write data |
| bus_ready | output | 1 | Transfer completes at this clock edge |
| bus_err | output | 1 | Error response for the current read |
| bus_rdata | output | DW | Read data |
| imm_wr | output | 1 | Immediate write strobe for untracked registers |
| core_rdata | input | DW | Core read data for untracked addresses |
| fclk | input | 1 | Functional clock |
| frst_n | input | 1 | Functional-domain reset, active low |
| fn_wr_stb | output | 5 | Per-register write strobe, functional domain |
| fn_wr_data | output | 5*DW | Per-register write data, register i at bits i*DW upward |
| fn_soft_rst | output | 1 | Soft reset strobe, functional domain |

## Verification
The bench issues back-to-back writes to one register, so the second is certain to land while the first is pending. A design that did not drop the second write would deliver it to the core, or overwrite the held data mid-crossing. Reads made between those writes and the flag clearing must error, or the bench would see stale data. The bench checks non-posted writes for a multi-cycle stall and a clear pending word; a design that completed them early would leave a set flag behind. It also checks soft reset for reset-done going low and then high again, and for posted mode coming back on, with a functional clock unrelated to the bus clock throughout.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    localparam int NTRK = 5;
    localparam int IW   = $clog2(NTRK);

    localparam logic [7:0] A_SYS  = 8'h14;
    localparam logic [7:0] A_PEND = 8'h34;
    localparam logic [7:0] A_IFC  = 8'h40;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HOLD = 2'd1,
        S_WAIT = 2'd2
    } bstate_e;

    // Address of tracked register i; order fixes the bit in the pending word.
    function automatic logic [7:0] trk_addr(input int i);
        case (i)
            0:       trk_addr = 8'h24;
            1:       trk_addr = 8'h28;
            2:       trk_addr = 8'h2C;
            3:       trk_addr = 8'h30;
            default: trk_addr = 8'h38;
        endcase
    endfunction

endpackage

// File: rtl/pwt_hs_chan.sv
module pwt_hs_chan #(
    parameter int DW = 32
) (
    input  logic          bclk,
    input  logic          brst_n,
    input  logic          launch,
    input  logic [DW-1:0] din,
    output logic          pend,
    output logic [DW-1:0] hold_q,
    input  logic          fclk,
    input  logic          frst_n,
    output logic          fstb
);

    logic req_t, ack_m, ack_s;
    logic rq_m, rq_s, rq_d;

    // bus side: toggle request and hold data while pending
    always_ff @(posedge bclk or negedge brst_n) begin
        if (!brst_n) begin
            req_t  <= 1'b0;
            hold_q <= '0;
            ack_m  <= 1'b0;
            ack_s  <= 1'b0;
        end else begin
            ack_m <= rq_d;
            ack_s <= ack_m;
            if (launch) begin
                req_t  <= ~req_t;
                hold_q <= din;
            end
        end
    end

    assign pend = req_t ^ ack_s;

    // functional side: two-flop synchronizer plus edge detect
    always_ff @(posedge fclk or negedge frst_n) begin
        if (!frst_n) begin
            rq_m <= 1'b0;
            rq_s <= 1'b0;
            rq_d <= 1'b0;
        end else begin
            rq_m <= req_t;
            rq_s <= rq_m;
            rq_d <= rq_s;
        end
    end

    assign fstb = rq_s ^ rq_d;

    // R4
    hold_stable_chk: assert property (@(posedge bclk) disable iff (!brst_n)
        (pend && $past(pend)) |-> $stable(hold_q));

    // R3
    launch_idle_chk: assert property (@(posedge bclk) disable iff (!brst_n)
        launch |-> !pend);

    // R3
    fstb_pulse_chk: assert property (@(posedge fclk) disable iff (!frst_n)
        fstb |=> !fstb);

endmodule

// File: rtl/pwt_bus_fsm.sv
module pwt_bus_fsm
    import pwt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel,
    input  logic            wr,
    input  logic            hit_trk,
    input  logic [IW-1:0]   hit_idx,
    input  logic            hit_loc,
    input  logic            posted,
    input  logic [NTRK-1:0] pend,
    output logic            ready,
    output logic            err,
    output logic [NTRK-1:0] launch,
    output logic            loc_wr,
    output logic            imm_wr
);

    bstate_e         state, nxt;
    logic [IW-1:0]   hidx, nidx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            hidx  <= '0;
        end else begin
            state <= nxt;
            hidx  <= nidx;
        end
    end

    always_comb begin
        nxt    = state;
        nidx   = hidx;
        ready  = 1'b0;
        err    = 1'b0;
        launch = '0;
        loc_wr = 1'b0;
        imm_wr = 1'b0;
        unique case (state)
            S_IDLE: begin
                ready = 1'b1;
                if (sel) begin
                    if (wr && hit_trk && !posted) begin
                        ready = 1'b0;
                        nidx  = hit_idx;
                        if (!pend[hit_idx]) begin
                            launch[hit_idx] = 1'b1;
                            nxt = S_WAIT;
                        end else begin
                            nxt = S_HOLD;
                        end
                    end else if (wr && hit_trk) begin
                        if (!pend[hit_idx])
                            launch[hit_idx] = 1'b1;
                    end else if (wr) begin
                        loc_wr = hit_loc;
                        imm_wr = !hit_loc;
                    end else begin
                        err = hit_trk && pend[hit_idx];
                    end
                end
            end
            S_HOLD: begin
                if (!pend[hidx]) begin
                    launch[hidx] = 1'b1;
                    nxt = S_WAIT;
                end
            end
            S_WAIT: begin
                if (!pend[hidx]) begin
                    ready = 1'b1;
                    nxt   = S_IDLE;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // R2
    launch_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(launch));

    // R5
    err_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (ready && sel && !wr));

endmodule

// File: rtl/pwt_tracker.sv
module pwt_tracker
    import pwt_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic               bclk,
    input  logic               brst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic               bus_ready,
    output logic               bus_err,
    output logic [DW-1:0]      bus_rdata,
    output logic               imm_wr,
    input  logic [DW-1:0]      core_rdata,
    input  logic               fclk,
    input  logic               frst_n,
    output logic [NTRK-1:0]    fn_wr_stb,
    output logic [NTRK*DW-1:0] fn_wr_data,
    output logic               fn_soft_rst
);

    localparam logic [AW-1:0] L_SYS  = AW'(A_SYS);
    localparam logic [AW-1:0] L_PEND = AW'(A_PEND);
    localparam logic [AW-1:0] L_IFC  = AW'(A_IFC);

    logic [NTRK-1:0] pend, launch;
    logic [DW-1:0]   hold_q [NTRK];
    logic            hit_trk, hit_loc, loc_wr;
    logic [IW-1:0]   hit_idx;
    logic            posted, rst_done, rst_pend, rst_pend_q, rst_go;
    logic            rst_hold;

    // address decode
    always_comb begin
        hit_trk = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < NTRK; i++) begin
            if (bus_addr == AW'(trk_addr(i))) begin
                hit_trk = 1'b1;
                hit_idx = IW'(i);
            end
        end
        hit_loc = (bus_addr == L_SYS) || (bus_addr == L_PEND) || (bus_addr == L_IFC);
    end

    pwt_bus_fsm u_fsm (
        .clk     (bclk),
        .rst_n   (brst_n),
        .sel     (bus_sel),
        .wr      (bus_wr),
        .hit_trk (hit_trk),
        .hit_idx (hit_idx),
        .hit_loc (hit_loc),
        .posted  (posted),
        .pend    (pend),
        .ready   (bus_ready),
        .err     (bus_err),
        .launch  (launch),
        .loc_wr  (loc_wr),
        .imm_wr  (imm_wr)
    );

    for (genvar g = 0; g < NTRK; g++) begin : g_chan
        pwt_hs_chan #(.DW(DW)) u_chan (
            .bclk   (bclk),
            .brst_n (brst_n),
            .launch (launch[g]),
            .din    (bus_wdata),
            .pend   (pend[g]),
            .hold_q (hold_q[g]),
            .fclk   (fclk),
            .frst_n (frst_n),
            .fstb   (fn_wr_stb[g])
        );
        assign fn_wr_data[g*DW +: DW] = hold_q[g];

        // R2
        pend_src_chk: assert property (@(posedge bclk) disable iff (!brst_n)
            $rose(pend[g]) |-> $past(bus_sel && bus_wr));
    end

    // soft reset crossing
    assign rst_go = loc_wr && (bus_addr == L_IFC) && bus_wdata[1] && !rst_pend;

    logic rst_stb;
    pwt_hs_chan #(.DW(1)) u_rst (
        .bclk   (bclk),
        .brst_n (brst_n),
        .launch (rst_go),
        .din    (1'b1),
        .pend   (rst_pend),
        .hold_q (rst_hold),
        .fclk   (fclk),
        .frst_n (frst_n),
        .fstb   (rst_stb)
    );
    assign fn_soft_rst = rst_stb & rst_hold;

    always_ff @(posedge bclk or negedge brst_n) begin
        if (!brst_n) begin
            posted     <= 1'b1;
            rst_done   <= 1'b1;
            rst_pend_q <= 1'b0;
        end else begin
            rst_pend_q <= rst_pend;
            if (loc_wr && bus_addr == L_IFC)
                posted <= bus_wdata[2];
            if (rst_go)
                rst_done <= 1'b0;
            if (rst_pend_q && !rst_pend) begin
                rst_done <= 1'b1;
                posted   <= 1'b1;
            end
        end
    end

    // read mux
    always_comb begin
        bus_rdata = core_rdata;
        if (hit_trk)
            bus_rdata = hold_q[hit_idx];
        else if (bus_addr == L_PEND)
            bus_rdata = DW'(pend);
        else if (bus_addr == L_IFC)
            bus_rdata = DW'({posted, rst_pend, 1'b0});
        else if (bus_addr == L_SYS)
            bus_rdata = DW'(rst_done);
    end

    // R8
    rst_done_chk: assert property (@(posedge bclk) disable iff (!brst_n)
        rst_pend |-> !rst_done);

endmodule

// File: tb/pwt_tracker_test.sv
module pwt_tracker_test;

    localparam int DW = 32;
    localparam int NT = 5;

    logic bclk = 0, fclk = 0, brst_n = 0, frst_n = 0;
    logic bus_sel = 0, bus_wr = 0;
    logic [7:0] bus_addr = 0;
    logic [DW-1:0] bus_wdata = 0;
    logic bus_ready, bus_err, imm_wr, fn_soft_rst;
    logic [DW-1:0] bus_rdata, core_rdata;
    logic [NT-1:0] fn_wr_stb;
    logic [NT*DW-1:0] fn_wr_data;

    always #4 bclk = ~bclk;
    always #13.5 fclk = ~fclk;

    assign core_rdata = {24'hA5A5A5, bus_addr};

    pwt_tracker uut (
        .bclk(bclk), .brst_n(brst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_err(bus_err), .bus_rdata(bus_rdata), .imm_wr(imm_wr),
        .core_rdata(core_rdata), .fclk(fclk), .frst_n(frst_n),
        .fn_wr_stb(fn_wr_stb), .fn_wr_data(fn_wr_data), .fn_soft_rst(fn_soft_rst)
    );

    int checks = 0, errors = 0;
    int got_cnt [NT];
    logic [DW-1:0] got_dat [NT];
    int rst_cnt = 0;
    int cyc = 0;
    bit done = 0;

    initial for (int i = 0; i < NT; i++) begin got_cnt[i] = 0; got_dat[i] = 0; end

    always @(negedge fclk) begin
        for (int i = 0; i < NT; i++)
            if (fn_wr_stb[i]) begin
                got_cnt[i]++;
                got_dat[i] = fn_wr_data[i*DW +: DW];
            end
        if (fn_soft_rst) rst_cnt++;
    end

    function automatic logic [7:0] reg_addr(input int i);
        case (i)
            0: return 8'h24;
            1: return 8'h28;
            2: return 8'h2C;
            3: return 8'h30;
            default: return 8'h38;
        endcase
    endfunction

    function automatic logic [DW-1:0] pend_word(input int i);
        return DW'(1) << i;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [7:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output logic er, output logic im,
                        output int stall);
        logic r;
        stall = 0;
        @(negedge bclk);
        bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        forever begin
            #2;
            r = bus_ready; er = bus_err; rd = bus_rdata; im = imm_wr;
            @(posedge bclk);
            if (r) break;
            stall++;
            @(negedge bclk);
        end
        @(negedge bclk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] rd; logic er, im; int st;
        xfer(1'b1, a, d, rd, er, im, st);
    endtask

    task automatic rd(input logic [7:0] a, output logic [DW-1:0] v, output logic er);
        logic im; int st;
        xfer(1'b0, a, '0, v, er, im, st);
    endtask

    task automatic wait_clear(input string req);
        logic [DW-1:0] v; logic er;
        for (int k = 0; k < 200; k++) begin
            rd(8'h34, v, er);
            if (v == 0) return;
        end
        chk(req, v, 0);
    endtask

    always @(posedge bclk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v, d1, d2;
        logic er, im;
        int st, idx, c0;
        void'($urandom(32'd20240611));
        repeat (5) @(posedge bclk);
        brst_n = 1; frst_n = 1;
        repeat (3) @(negedge bclk);

        // R1 reset state
        #2 chk("R1 ready", DW'(bus_ready), 1);
        rd(8'h34, v, er); chk("R1 pend", v, 0);
        rd(8'h40, v, er); chk("R1 ifc", v, 4);
        rd(8'h14, v, er); chk("R1 sys", v, 1);

        // R2 posted accept in first cycle, flag set
        xfer(1'b1, 8'h28, 32'h1111_2222, v, er, im, st);
        chk("R2 stall", DW'(st), 0);
        rd(8'h34, v, er); chk("R2 pend bit1", v, pend_word(1));
        // R5 read while pending errors
        rd(8'h28, v, er); chk("R5 err", DW'(er), 1);
        wait_clear("R3 clear");
        chk("R3 count", DW'(got_cnt[1]), 1);
        chk("R3 data", got_dat[1], 32'h1111_2222);
        rd(8'h28, v, er); chk("R5 readback", v, 32'h1111_2222);
        chk("R5 no err", DW'(er), 0);

        // R4 / R5 random back-to-back writes
        for (int n = 0; n < 40; n++) begin
            idx = $urandom_range(0, NT-1);
            d1 = $urandom; d2 = $urandom;
            c0 = got_cnt[idx];
            wr(reg_addr(idx), d1);
            wr(reg_addr(idx), d2);
            rd(8'h34, v, er); chk("R2 pend rand", v, pend_word(idx));
            rd(reg_addr(idx), v, er); chk("R5 err rand", DW'(er), 1);
            wait_clear("R3 clear rand");
            chk("R4 count", DW'(got_cnt[idx] - c0), 1);
            chk("R4 data", got_dat[idx], d1);
            rd(reg_addr(idx), v, er); chk("R4 readback", v, d1);
        end

        // R10 independent channels
        wr(8'h24, 32'hAAAA_0001);
        wr(8'h38, 32'hBBBB_0002);
        rd(8'h34, v, er); chk("R10 both pend", v, pend_word(0) | pend_word(4));
        wait_clear("R10 clear");
        chk("R10 ctrl data", got_dat[0], 32'hAAAA_0001);
        chk("R10 match data", got_dat[4], 32'hBBBB_0002);

        // R6 immediate write
        xfer(1'b1, 8'h1C, 32'h5, v, er, im, st);
        chk("R6 imm strobe", DW'(im), 1);
        rd(8'h34, v, er); chk("R6 no pend", v, 0);
        rd(8'h3C, v, er); chk("R6 core read", v, 32'hA5A5A53C);

        // R9 read-only local words
        wr(8'h34, 32'hFFFF_FFFF);
        rd(8'h34, v, er); chk("R9 pend ro", v, 0);
        chk("R9 no err", DW'(er), 0);
        wr(8'h14, 32'h0);
        rd(8'h14, v, er); chk("R9 sys ro", v, 1);

        // R7 non-posted
        wr(8'h40, 32'h0);
        rd(8'h40, v, er); chk("R7 ifc", v, 0);
        c0 = got_cnt[2];
        xfer(1'b1, 8'h2C, 32'hCAFE_F00D, v, er, im, st);
        chk("R7 stalled", DW'(st >= 3), 1);
        rd(8'h34, v, er); chk("R7 pend zero", v, 0);
        chk("R7 core data", got_dat[2], 32'hCAFE_F00D);
        chk("R7 core count", DW'(got_cnt[2] - c0), 1);

        // R8 soft reset
        wr(8'h40, 32'h2);
        rd(8'h14, v, er); chk("R8 done low", v, 0);
        for (int k = 0; k < 200; k++) begin
            rd(8'h14, v, er);
            if (v == 1) break;
        end
        chk("R8 done high", v, 1);
        chk("R8 strobe", DW'(rst_cnt), 1);
        rd(8'h40, v, er); chk("R8 posted restored", v, 4);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule